// File: doc/BRIEF.md
# Paged Address Translation Unit

This block converts 16-bit logical byte addresses into physical byte addresses using a register-held page table with 64 entries. The address is split into a page number and an in-page offset. A page-table entry that is marked resident supplies a frame number. The frame number replaces the page number, and the offset is carried through unchanged. A reference to a page that is not resident produces a fault strobe instead of an address. The result is registered, so it appears one clock after the request.

The host fills the table through a write port that carries a page index, a frame number and a resident bit. Alongside the translation, the unit records for every physical frame whether a store has modified it since the frame was last given a page. That record is exported as a flag vector, so replacement software can tell which frames must be written back before reuse.

Top module: `paged_xlate_unit`

## Requirements
- R1: While reset is asserted, and right after it is released, both strobes are low, every dirty flag is 0 and every page is non-resident, so any lookup faults.
- R2: The page number is logical address bits [15:10] and the offset is bits [9:0]. Physical address bits [9:0] always equal the offset of the request.
- R3: A lookup of a resident page drives `xlt_ok` high for exactly one cycle, on the clock after the request, with `xlt_paddr` = {frame, offset}, and `xlt_fault` low.
- R4: A lookup of a non-resident page drives `xlt_fault` high for one cycle, on the clock after the request, with `xlt_ok` low and `xlt_paddr` = 0.
- R5: A cycle with no request leaves both strobes low on the following cycle.
- R6: A table write updates its entry at the clock edge. A lookup issued in the same cycle as a write to its page still sees the old entry, and lookups in later cycles see the new entry.
- R7: A store lookup (`lk_store`=1) that hits sets the dirty flag of the target frame at the same edge. A read lookup changes no dirty flag.
- R8: A store lookup that faults changes no dirty flag.
- R9: A table write with the resident bit set clears the dirty flag of the written frame. This clear wins over a same-cycle store to that frame. A write with the resident bit clear changes no dirty flag.
- R10: With page 3 mapped to frame 4, logical 0x0C05 translates to physical 0x1005.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request for this cycle |
| lk_addr | input | 16 | Logical byte address |
| lk_store | input | 1 | 1 = the access is a store, 0 = a read |
| tw_en | input | 1 | Page-table write enable |
| tw_page | input | 6 | Page index to write |
| tw_frame | input | 6 | Frame number for the entry |
| tw_resident | input | 1 | Resident bit for the entry |
| xlt_ok | output | 1 | Translation valid strobe |
| xlt_fault | output | 1 | Page-fault strobe |
| xlt_paddr | output | 16 | Physical address (0 on a fault) |
| frame_dirty | output | 64 | Per-frame modified flags, bit n = frame n |

## Verification
The translation strobes and address are due one clock after the request edge. The dirty flags and table contents change at the request edge itself, so a changed entry is first seen by a lookup issued in the next cycle. The bench drives inputs at the falling edge and updates its own model at the rising edge from those inputs. It compares strobes, address and dirty vector at the following falling edge, every cycle. A same-cycle write and lookup checks the old-entry rule. A same-cycle write and store checks the rule that the clear wins.

// File: rtl/pxu_pkg.sv
package pxu_pkg;
  parameter int PXU_PAGE_W  = 6;
  parameter int PXU_OFFS_W  = 10;
  parameter int PXU_FRAME_W = 6;

  typedef enum logic [1:0] {
    RES_IDLE  = 2'd0,
    RES_HIT   = 2'd1,
    RES_FAULT = 2'd2
  } xlt_res_e;
endpackage

// File: rtl/pxu_page_table.sv
module pxu_page_table #(
  parameter int PAGE_W  = 6,
  parameter int FRAME_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [PAGE_W-1:0]  wr_page,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic               wr_resident,
  input  logic [PAGE_W-1:0]  rd_page,
  output logic               rd_resident,
  output logic [FRAME_W-1:0] rd_frame
);
  localparam int NPAGES = 1 << PAGE_W;

  logic               res_q [NPAGES];
  logic [FRAME_W-1:0] frm_q [NPAGES];

  for (genvar p = 0; p < NPAGES; p++) begin : g_entry
    logic sel;
    assign sel = wr_en && (wr_page == PAGE_W'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   res_q[p] <= 1'b0;
      else if (sel) res_q[p] <= wr_resident;
    end

    always_ff @(posedge clk) begin
      if (sel) frm_q[p] <= wr_frame;
    end
  end

  assign rd_resident = res_q[rd_page];
  assign rd_frame    = frm_q[rd_page];
endmodule

// File: rtl/pxu_dirty_track.sv
module pxu_dirty_track #(
  parameter int FRAME_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      set_en,
  input  logic [FRAME_W-1:0]        set_frame,
  input  logic                      clr_en,
  input  logic [FRAME_W-1:0]        clr_frame,
  output logic [(1<<FRAME_W)-1:0]   dirty
);
  localparam int NFRAMES = 1 << FRAME_W;

  logic [NFRAMES-1:0] dirty_q, dirty_n;

  always_comb begin
    dirty_n = dirty_q;
    if (set_en) dirty_n[set_frame] = 1'b1;
    if (clr_en) dirty_n[clr_frame] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dirty_q <= '0;
    else        dirty_q <= dirty_n;
  end

  assign dirty = dirty_q;
endmodule

// File: rtl/pxu_xlate_stage.sv
module pxu_xlate_stage
  import pxu_pkg::*;
#(
  parameter int OFFS_W  = 10,
  parameter int FRAME_W = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req,
  input  logic                       hit,
  input  logic [FRAME_W-1:0]         frame,
  input  logic [OFFS_W-1:0]          offset,
  output logic                       ok,
  output logic                       fault,
  output logic [FRAME_W+OFFS_W-1:0]  paddr
);
  localparam int PA_W = FRAME_W + OFFS_W;

  xlt_res_e        res_q, res_n;
  logic [PA_W-1:0] pa_q, pa_n;
  logic            pa_en;

  always_comb begin
    res_n = RES_IDLE;
    pa_n  = '0;
    pa_en = req;
    if (req) begin
      res_n = hit ? RES_HIT : RES_FAULT;
      pa_n  = hit ? {frame, offset} : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= RES_IDLE;
    else        res_q <= res_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pa_q <= '0;
    else if (pa_en) pa_q <= pa_n;
  end

  assign ok    = (res_q == RES_HIT);
  assign fault = (res_q == RES_FAULT);
  assign paddr = pa_q;
endmodule

// File: rtl/paged_xlate_unit.sv
module paged_xlate_unit
  import pxu_pkg::*;
#(
  parameter int PAGE_W  = PXU_PAGE_W,
  parameter int OFFS_W  = PXU_OFFS_W,
  parameter int FRAME_W = PXU_FRAME_W,
  localparam int LA_W    = PAGE_W + OFFS_W,
  localparam int PA_W    = FRAME_W + OFFS_W,
  localparam int NFRAMES = 1 << FRAME_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_req,
  input  logic [LA_W-1:0]    lk_addr,
  input  logic               lk_store,
  input  logic               tw_en,
  input  logic [PAGE_W-1:0]  tw_page,
  input  logic [FRAME_W-1:0] tw_frame,
  input  logic               tw_resident,
  output logic               xlt_ok,
  output logic               xlt_fault,
  output logic [PA_W-1:0]    xlt_paddr,
  output logic [NFRAMES-1:0] frame_dirty
);
  logic [PAGE_W-1:0]  lk_page;
  logic [OFFS_W-1:0]  lk_offs;
  logic               pt_resident;
  logic [FRAME_W-1:0] pt_frame;
  logic               store_hit;

  assign lk_page = lk_addr[LA_W-1:OFFS_W];
  assign lk_offs = lk_addr[OFFS_W-1:0];

  pxu_page_table #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_table (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (tw_en),
    .wr_page     (tw_page),
    .wr_frame    (tw_frame),
    .wr_resident (tw_resident),
    .rd_page     (lk_page),
    .rd_resident (pt_resident),
    .rd_frame    (pt_frame)
  );

  assign store_hit = lk_req && lk_store && pt_resident;

  pxu_dirty_track #(.FRAME_W(FRAME_W)) u_dirty (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_en    (store_hit),
    .set_frame (pt_frame),
    .clr_en    (tw_en && tw_resident),
    .clr_frame (tw_frame),
    .dirty     (frame_dirty)
  );

  pxu_xlate_stage #(.OFFS_W(OFFS_W), .FRAME_W(FRAME_W)) u_stage (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (lk_req),
    .hit    (pt_resident),
    .frame  (pt_frame),
    .offset (lk_offs),
    .ok     (xlt_ok),
    .fault  (xlt_fault),
    .paddr  (xlt_paddr)
  );
endmodule

// File: rtl/pxu_chk.sv
module pxu_chk #(
  parameter int LA_W    = 16,
  parameter int PA_W    = 16,
  parameter int OFFS_W  = 10,
  parameter int NFRAMES = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_req,
  input logic [LA_W-1:0]    lk_addr,
  input logic               lk_store,
  input logic               tw_en,
  input logic               xlt_ok,
  input logic               xlt_fault,
  input logic [PA_W-1:0]    xlt_paddr,
  input logic [NFRAMES-1:0] frame_dirty
);
  // R3
  ok_fault_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(xlt_ok && xlt_fault));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(lk_req) |-> (!xlt_ok && !xlt_fault));

  // R4
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xlt_fault |-> (xlt_paddr == '0));

  // R2
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xlt_ok |-> (xlt_paddr[OFFS_W-1:0] == $past(lk_addr[OFFS_W-1:0])));

  // R7
  dirty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!(lk_req && lk_store) && !tw_en) |-> $stable(frame_dirty));
endmodule

bind paged_xlate_unit pxu_chk #(
  .LA_W(LA_W), .PA_W(PA_W), .OFFS_W(OFFS_W), .NFRAMES(NFRAMES)
) u_pxu_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lk_req      (lk_req),
  .lk_addr     (lk_addr),
  .lk_store    (lk_store),
  .tw_en       (tw_en),
  .xlt_ok      (xlt_ok),
  .xlt_fault   (xlt_fault),
  .xlt_paddr   (xlt_paddr),
  .frame_dirty (frame_dirty)
);

// File: tb/tb_paged_xlate_unit.sv
module tb_paged_xlate_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        lk_req, lk_store, tw_en, tw_resident;
  logic [15:0] lk_addr;
  logic [5:0]  tw_page, tw_frame;
  logic        xlt_ok, xlt_fault;
  logic [15:0] xlt_paddr;
  logic [63:0] frame_dirty;

  always #10 clk = ~clk;

  paged_xlate_unit dut (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_addr(lk_addr),
    .lk_store(lk_store), .tw_en(tw_en), .tw_page(tw_page),
    .tw_frame(tw_frame), .tw_resident(tw_resident), .xlt_ok(xlt_ok),
    .xlt_fault(xlt_fault), .xlt_paddr(xlt_paddr), .frame_dirty(frame_dirty)
  );

  int checks = 0;
  int errors = 0;

  bit          m_res [64];
  int          m_frm [64];
  bit [63:0]   m_dirty;
  bit          e_ok, e_fault;
  bit [15:0]   e_paddr;

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    check(tag, "ok", 64'(xlt_ok), 64'(e_ok));
    check(tag, "fault", 64'(xlt_fault), 64'(e_fault));
    if (e_ok || e_fault) check(tag, "paddr", 64'(xlt_paddr), 64'(e_paddr));
    check(tag, "dirty", frame_dirty, m_dirty);
  endtask

  // one clock: model reacts to the inputs present at the rising edge
  task automatic step(string tag);
    int pg;
    @(posedge clk);
    pg = int'(lk_addr[15:10]);
    e_ok = 0; e_fault = 0;
    if (lk_req) begin
      if (m_res[pg]) begin
        e_ok = 1;
        e_paddr = {6'(m_frm[pg]), lk_addr[9:0]};
        if (lk_store) m_dirty[m_frm[pg]] = 1'b1;
      end else begin
        e_fault = 1;
        e_paddr = 16'h0;
      end
    end
    if (tw_en) begin
      m_res[tw_page] = tw_resident;
      m_frm[tw_page] = int'(tw_frame);
      if (tw_resident) m_dirty[tw_frame] = 1'b0;
    end
    @(negedge clk);
    compare(tag);
    lk_req = 0; lk_store = 0; tw_en = 0;
  endtask

  task automatic lookup(logic [15:0] a, logic st, string tag);
    lk_req = 1; lk_addr = a; lk_store = st;
    step(tag);
  endtask

  task automatic tw(int pg, int fr, logic r, string tag);
    tw_en = 1; tw_page = 6'(pg); tw_frame = 6'(fr); tw_resident = r;
    step(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 0; lk_req = 0; lk_store = 0; lk_addr = '0;
    tw_en = 0; tw_page = '0; tw_frame = '0; tw_resident = 0;
    for (int i = 0; i < 64; i++) begin m_res[i] = 0; m_frm[i] = 0; end
    m_dirty = '0; e_ok = 0; e_fault = 0; e_paddr = '0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    step("R1");
    // R1 / R4: every page faults after reset
    for (int p = 0; p < 64; p += 9) lookup(16'((p << 10) | 16'h155), p[0], "R1");
    step("R5");
    // R10 worked example
    tw(3, 4, 1, "R6");
    lookup(16'h0C05, 0, "R10");
    check("R10", "example paddr", 64'(xlt_paddr), 64'h1005);
    // load a spread of pages
    for (int p = 8; p < 24; p++) tw(p, (p * 5 + 7) & 63, 1, "R6");
    // R2 / R3: various offsets, back to back
    for (int p = 8; p < 24; p++) lookup(16'((p << 10) | ((p * 97) & 16'h3FF)), 0, "R3");
    lookup(16'h2000, 0, "R2");
    lookup(16'h23FF, 0, "R2");
    step("R5");
    step("R5");
    // R6: same-cycle write and lookup of the same page
    lk_req = 1; lk_addr = 16'h2C11; lk_store = 0;
    tw_en = 1; tw_page = 6'd11; tw_frame = 6'd50; tw_resident = 1;
    step("R6");
    lookup(16'h2C11, 0, "R6");
    lk_req = 1; lk_addr = 16'h3044; lk_store = 0;
    tw_en = 1; tw_page = 6'd12; tw_frame = 6'd0; tw_resident = 0;
    step("R6");
    lookup(16'h3044, 0, "R4");
    // R7: stores set dirty, reads do not
    lookup(16'h0C20, 1, "R7");
    lookup(16'h2410, 0, "R7");
    lookup(16'h2801, 1, "R7");
    // R8: faulting store
    lookup(16'hF800, 1, "R8");
    lookup(16'h3044, 1, "R8");
    // R9: resident write clears; non-resident write keeps
    tw(40, 4, 0, "R9");
    tw(41, 4, 1, "R9");
    lookup(16'h0C00, 1, "R9");
    lk_req = 1; lk_addr = 16'h0C00; lk_store = 1;
    tw_en = 1; tw_page = 6'd42; tw_frame = 6'd4; tw_resident = 1;
    step("R9");
    step("R5");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule